// File: doc/BRIEF.md
# IMU Burst Frame Unpacker

This block sits behind a serial-bus master that has just issued a burst read to an inertial sensor. The master hands over the 16-bit response words one at a time with a valid strobe. The sensor may send one or two meaningless filler words before the frame begins, so the block hunts for a fixed start marker instead of assuming a fixed position. Once the marker is found, the block captures the seventeen data words that follow. It then presents the whole frame at once as parallel fields: status, temperature, six 32-bit motion channels, the sample counter and the 32-bit CRC.

Each motion channel and the CRC arrive as two halves, with the low half first. The block puts them back together with the upper half on top. A `frame_start` strobe arms the block before each burst. A single-cycle `out_valid` pulse marks a completed frame. A single-cycle `frame_error` pulse marks a burst that showed no marker within its first three words.

Top module: `imu_burst_unpacker`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid` and `frame_error` are 0 and every output field is 0.
- R2: After `frame_start`, the marker word 0xA5A5 is recognized when it is the 1st, 2nd or 3rd valid word. The valid word right after the marker is data word 0.
- R3: `out_status` carries data word 0 and `out_temp` carries data word 1.
- R4: Motion channel c (c = 0..5: gyro X, Y, Z, then accel X, Y, Z) is driven on `out_motion[32*c+31:32*c]`. Its bits 31:16 are data word 3+2c and its bits 15:0 are data word 2+2c.
- R5: `out_counter` carries data word 14. `out_crc` carries data word 16 in bits 31:16 and data word 15 in bits 15:0.
- R6: `out_valid` is high for exactly one cycle: the cycle after the one in which data word 16 is presented with `word_valid` high. All output fields update in that same cycle.
- R7: If none of the first three valid words after `frame_start` is 0xA5A5, `frame_error` pulses for one cycle in the cycle after the third word. No `out_valid` follows, and later words are ignored until the next `frame_start`.
- R8: Valid words after data word 16 and before the next `frame_start` are ignored. This holds even if they equal 0xA5A5.
- R9: Cycles with `word_valid` low neither advance the search nor capture data.
- R10: `frame_start` restarts the marker search at once, even in the middle of a frame. A word presented in the same cycle as `frame_start` is discarded.
- R11: All output fields hold their values in every cycle in which `out_valid` is low.
- R12: After reset, words are ignored until the first `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Arms the block for a new burst; restarts the marker search |
| word_valid | input | 1 | `word_data` carries a response word this cycle |
| word_data | input | 16 | Response word from the serial-bus master |
| out_valid | output | 1 | One-cycle pulse: frame fields are updated |
| frame_error | output | 1 | One-cycle pulse: no marker in the first three words |
| out_status | output | 16 | Status/error flag word |
| out_temp | output | 16 | Temperature word |
| out_motion | output | 192 | Six 32-bit motion channels, channel c at bits 32c+31:32c |
| out_counter | output | 16 | Sample counter / timestamp word |
| out_crc | output | 32 | Frame CRC, upper half in bits 31:16 |

## Verification
Both pulses and the field update become visible one clock after the input cycle that causes them. `out_valid` follows the last data word, and `frame_error` follows the third word that is not a marker. The bench drives each input on the falling edge and advances a queue-based reference model on the rising edge. It compares every output on the next falling edge, so the expected one-cycle latency is checked on every clock, including gaps, aborted frames and ignored words.

// File: rtl/imu_burst_pkg.sv
package imu_burst_pkg;

    localparam int WORD_W       = 16;
    localparam logic [WORD_W-1:0] SYNC_WORD = 16'hA5A5;
    localparam int SEARCH_SLOTS = 3;
    localparam int NUM_CHAN     = 6;

    // position of each field among the data words after the marker
    localparam int F_STATUS  = 0;
    localparam int F_TEMP    = 1;
    localparam int F_CHAN0   = 2;
    localparam int F_COUNT   = F_CHAN0 + 2 * NUM_CHAN;
    localparam int F_CRC_LO  = F_COUNT + 1;
    localparam int F_CRC_HI  = F_COUNT + 2;
    localparam int NUM_DATA  = F_CRC_HI + 1;
    localparam int IDX_W     = $clog2(NUM_DATA);
    localparam int POS_W     = $clog2(SEARCH_SLOTS);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HUNT,
        PH_COLLECT,
        PH_SPENT
    } phase_e;

    typedef struct packed {
        logic [WORD_W-1:0]                  status;
        logic [WORD_W-1:0]                  temp;
        logic [NUM_CHAN-1:0][2*WORD_W-1:0]  motion;
        logic [WORD_W-1:0]                  counter;
        logic [2*WORD_W-1:0]                crc;
    } frame_t;

    function automatic logic [2*WORD_W-1:0] join_halves(
        input logic [WORD_W-1:0] lo,
        input logic [WORD_W-1:0] hi
    );
        return {hi, lo};
    endfunction

endpackage

// File: rtl/imu_burst_ctrl.sv
module imu_burst_ctrl
    import imu_burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              cap_en,
    output logic [IDX_W-1:0]  cap_idx,
    output logic              frame_done,
    output logic              no_sync
);

    phase_e             phase_q;
    logic [POS_W-1:0]   pos_q;
    logic [IDX_W-1:0]   idx_q;
    logic               take;
    logic               is_sync;

    assign take    = word_valid && !frame_start;
    assign is_sync = (word_data == SYNC_WORD);

    assign cap_en     = take && (phase_q == PH_COLLECT);
    assign cap_idx    = idx_q;
    assign frame_done = cap_en && (idx_q == IDX_W'(NUM_DATA - 1));
    assign no_sync    = take && (phase_q == PH_HUNT) && !is_sync
                        && (pos_q == POS_W'(SEARCH_SLOTS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            pos_q   <= '0;
            idx_q   <= '0;
        end else if (frame_start) begin
            phase_q <= PH_HUNT;
            pos_q   <= '0;
            idx_q   <= '0;
        end else if (word_valid) begin
            unique case (phase_q)
                PH_HUNT: begin
                    if (is_sync) begin
                        phase_q <= PH_COLLECT;
                    end else if (no_sync) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        pos_q <= pos_q + 1'b1;
                    end
                end
                PH_COLLECT: begin
                    if (frame_done) begin
                        phase_q <= PH_SPENT;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/imu_word_store.sv
module imu_word_store
    import imu_burst_pkg::*;
#(
    parameter int DEPTH = NUM_DATA - 1
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [WORD_W-1:0]             wr_data,
    output logic [DEPTH-1:0][WORD_W-1:0]  words
);

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(k)) begin
                words[k] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/imu_field_unpack.sv
module imu_field_unpack
    import imu_burst_pkg::*;
(
    input  logic [NUM_DATA-1:0][WORD_W-1:0] words,
    output frame_t                          fields
);

    always_comb begin
        fields.status  = words[F_STATUS];
        fields.temp    = words[F_TEMP];
        for (int c = 0; c < NUM_CHAN; c++) begin
            fields.motion[c] = join_halves(words[F_CHAN0 + 2*c],
                                           words[F_CHAN0 + 2*c + 1]);
        end
        fields.counter = words[F_COUNT];
        fields.crc     = join_halves(words[F_CRC_LO], words[F_CRC_HI]);
    end

endmodule

// File: rtl/imu_burst_unpacker.sv
module imu_burst_unpacker
    import imu_burst_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   frame_start,
    input  logic                   word_valid,
    input  logic [15:0]            word_data,
    output logic                   out_valid,
    output logic                   frame_error,
    output logic [15:0]            out_status,
    output logic [15:0]            out_temp,
    output logic [NUM_CHAN*32-1:0] out_motion,
    output logic [15:0]            out_counter,
    output logic [31:0]            out_crc
);

    localparam int STORE_DEPTH = NUM_DATA - 1;

    logic                                 cap_en;
    logic [IDX_W-1:0]                     cap_idx;
    logic                                 frame_done;
    logic                                 no_sync;
    logic [STORE_DEPTH-1:0][WORD_W-1:0]   held_words;
    logic [NUM_DATA-1:0][WORD_W-1:0]      all_words;
    frame_t                               next_frame;
    frame_t                               frame_q;
    logic                                 valid_q;
    logic                                 err_q;

    imu_burst_ctrl i_ctrl (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .word_valid  (word_valid),
        .word_data   (word_data),
        .cap_en      (cap_en),
        .cap_idx     (cap_idx),
        .frame_done  (frame_done),
        .no_sync     (no_sync)
    );

    imu_word_store #(.DEPTH(STORE_DEPTH)) i_store (
        .clk     (clk),
        .wr_en   (cap_en),
        .wr_idx  (cap_idx),
        .wr_data (word_data),
        .words   (held_words)
    );

    // the final word is used straight from the input in its own cycle
    assign all_words = {word_data, held_words};

    imu_field_unpack i_unpack (
        .words  (all_words),
        .fields (next_frame)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= frame_done;
            err_q   <= no_sync;
            if (frame_done) begin
                frame_q <= next_frame;
            end
        end
    end

    assign out_valid   = valid_q;
    assign frame_error = err_q;
    assign out_status  = frame_q.status;
    assign out_temp    = frame_q.temp;
    assign out_motion  = frame_q.motion;
    assign out_counter = frame_q.counter;
    assign out_crc     = frame_q.crc;

endmodule

// File: rtl/imu_burst_checker.sv
module imu_burst_checker
    import imu_burst_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   frame_start,
    input logic                   word_valid,
    input logic [15:0]            word_data,
    input logic                   out_valid,
    input logic                   frame_error,
    input logic [NUM_CHAN*32-1:0] out_motion,
    input logic [31:0]            out_crc
);

    a_r6_valid_single: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    a_r6_valid_cause: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(word_valid) && !$past(frame_start)));

    a_r7_error_single: assert property (@(posedge clk) disable iff (rst)
        frame_error |=> !frame_error);

    a_r7_error_cause: assert property (@(posedge clk) disable iff (rst)
        frame_error |-> ($past(word_valid) && !$past(frame_start)
                         && $past(word_data) != SYNC_WORD));

    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && frame_error));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_crc) && $stable(out_motion)));

endmodule

bind imu_burst_unpacker imu_burst_checker i_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .word_valid  (word_valid),
    .word_data   (word_data),
    .out_valid   (out_valid),
    .frame_error (frame_error),
    .out_motion  (out_motion),
    .out_crc     (out_crc)
);

// File: tb/test_imu_burst_unpacker.sv
module test_imu_burst_unpacker;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         frame_start = 1'b0;
    logic         word_valid = 1'b0;
    logic [15:0]  word_data = '0;
    logic         out_valid;
    logic         frame_error;
    logic [15:0]  out_status;
    logic [15:0]  out_temp;
    logic [191:0] out_motion;
    logic [15:0]  out_counter;
    logic [31:0]  out_crc;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    // reference model state
    logic [15:0]  q[$];
    int           mode = 0;   // 0 ignore, 1 hunting, 2 collecting, 3 finished
    int           nfill = 0;
    logic         e_valid = 0, e_err = 0;
    logic [15:0]  e_status = 0, e_temp = 0, e_counter = 0;
    logic [191:0] e_motion = 0;
    logic [31:0]  e_crc = 0;

    always #10 clk = ~clk;

    imu_burst_unpacker i_imu_burst_unpacker (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .word_valid(word_valid), .word_data(word_data),
        .out_valid(out_valid), .frame_error(frame_error),
        .out_status(out_status), .out_temp(out_temp),
        .out_motion(out_motion), .out_counter(out_counter), .out_crc(out_crc)
    );

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [287:0] act, input logic [287:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_edge(input logic r, input logic fs, input logic v,
                              input logic [15:0] d);
        e_valid = 0;
        e_err   = 0;
        if (r) begin
            mode = 0; nfill = 0; q.delete();
            e_status = 0; e_temp = 0; e_counter = 0; e_motion = 0; e_crc = 0;
        end else if (fs) begin
            mode = 1; nfill = 0; q.delete();
        end else if (v) begin
            if (mode == 1) begin
                if (d == 16'hA5A5) mode = 2;
                else begin
                    nfill++;
                    if (nfill == 3) begin e_err = 1; mode = 0; end
                end
            end else if (mode == 2) begin
                q.push_back(d);
                if (q.size() == 17) begin
                    e_valid   = 1;
                    mode      = 3;
                    e_status  = q[0];
                    e_temp    = q[1];
                    for (int c = 0; c < 6; c++)
                        e_motion[32*c +: 32] = {q[3+2*c], q[2+2*c]};
                    e_counter = q[14];
                    e_crc     = {q[16], q[15]};
                end
            end
        end
    endtask

    task automatic compare_all();
        logic [287:0] a, e;
        a = {out_valid, frame_error, out_status, out_temp, out_motion, out_counter, out_crc};
        e = {e_valid, e_err, e_status, e_temp, e_motion, e_counter, e_crc};
        chk(a == e, cur_req, "cycle compare", a, e);
    endtask

    task automatic step(input logic r, input logic fs, input logic v,
                        input logic [15:0] d);
        rst = r; frame_start = fs; word_valid = v; word_data = d;
        @(posedge clk);
        model_edge(r, fs, v, d);
        @(negedge clk);
        compare_all();
    endtask

    task automatic word(input logic [15:0] d);
        step(0, 0, 1, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 16'hDEAD);
    endtask

    // fillers, marker, 17 data words base+k; gap inserts idle cycles
    task automatic burst(input int fillers, input logic [15:0] base, input bit gap);
        step(0, 1, 0, 16'h0);
        for (int i = 0; i < fillers; i++) word(16'h0F00 + 16'(i));
        if (gap) idle(2);
        word(16'hA5A5);
        for (int k = 0; k < 17; k++) begin
            word(base + 16'(k));
            if (gap && (k % 4 == 1)) idle(1);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(0, 0, 0, 0);
        chk(out_valid == 0 && frame_error == 0 && out_crc == 0 && out_motion == 0,
            "R1", "reset outputs", {out_valid, frame_error, out_crc}, 0);

        // R12: words before any frame_start are ignored
        cur_req = "R12";
        word(16'hA5A5);
        for (int k = 0; k < 18; k++) word(16'h7700 + 16'(k));
        idle(1);
        chk(out_crc == 0, "R12", "no capture before arm", out_crc, 0);

        // R2 R3 R4 R5 R6: marker at first position
        cur_req = "R2";
        burst(0, 16'h1000, 0);
        chk(out_valid == 1, "R6", "pulse after last word", out_valid, 1);
        chk(out_status == 16'h1000 && out_temp == 16'h1001, "R3", "status/temp",
            {out_status, out_temp}, {16'h1000, 16'h1001});
        chk(out_motion[31:0] == 32'h1003_1002, "R4", "gyro x halves",
            out_motion[31:0], 32'h1003_1002);
        chk(out_motion[191:160] == 32'h100D_100C, "R4", "accel z halves",
            out_motion[191:160], 32'h100D_100C);
        chk(out_counter == 16'h100E && out_crc == 32'h1010_100F, "R5", "counter/crc",
            {out_counter, out_crc}, {16'h100E, 32'h1010_100F});
        idle(1);
        chk(out_valid == 0, "R6", "pulse is one cycle", out_valid, 0);

        // R9: one filler with gaps
        cur_req = "R9";
        burst(1, 16'h2000, 1);
        idle(1);
        chk(out_crc == 32'h2010_200F, "R9", "gaps do not advance", out_crc, 32'h2010_200F);

        // R8: two fillers, then trailing words including markers
        cur_req = "R8";
        burst(2, 16'h3000, 0);
        word(16'hA5A5);
        for (int k = 0; k < 18; k++) word(16'h3900 + 16'(k));
        idle(2);
        chk(out_crc == 32'h3010_300F, "R8", "trailing words ignored", out_crc, 32'h3010_300F);

        // R7: no marker in first three words
        cur_req = "R7";
        step(0, 1, 0, 0);
        word(16'h1111); word(16'h2222); word(16'h3333);
        chk(frame_error == 1, "R7", "error pulse", frame_error, 1);
        word(16'hA5A5);
        chk(frame_error == 0, "R7", "error one cycle", frame_error, 0);
        for (int k = 0; k < 17; k++) word(16'h4400 + 16'(k));
        idle(1);
        chk(out_crc == 32'h3010_300F, "R7", "words after error ignored", out_crc, 32'h3010_300F);

        // R10: restart mid-frame; the word beside frame_start is dropped
        cur_req = "R10";
        step(0, 1, 0, 0);
        word(16'hA5A5);
        for (int k = 0; k < 5; k++) word(16'h5500 + 16'(k));
        step(0, 1, 1, 16'hA5A5);
        word(16'h0001);
        word(16'hA5A5);
        for (int k = 0; k < 17; k++) word(16'h6000 + 16'(k));
        chk(out_valid == 1 && out_status == 16'h6000, "R10", "restarted frame",
            {out_valid, out_status}, {1'b1, 16'h6000});

        // R2: third position, marker value inside data
        cur_req = "R2";
        step(0, 1, 0, 0);
        word(16'h0A0A); word(16'h0B0B); word(16'hA5A5);
        word(16'hA5A5);
        for (int k = 1; k < 17; k++) word(16'h7000 + 16'(k));
        chk(out_status == 16'hA5A5 && out_crc == 32'h7010_700F, "R2", "third slot marker",
            {out_status, out_crc}, {16'hA5A5, 32'h7010_700F});

        cur_req = "R11";
        idle(3);
        summary();
        $finish;
    end

endmodule